// File: doc/BRIEF.md
# Tagged register rename table

This block keeps, for each of six architectural registers of a small out-of-order core, either a committed value or the tag of the reservation station that will produce it. Tags 0 to 5 name stations A to F. Stations A to C serve one functional unit and D to F serve the other. At most one instruction dispatches per cycle, in program order, during decode. That instruction reads its two source registers and renames its destination to the station it was given.

Each table entry is a two-state machine. In `ENT_READY` the entry holds a value. In `ENT_PENDING` it holds a producer tag. Three transitions are named:

- `T_RENAME` (ready to pending): a dispatch names the register as its destination.
- `T_RETAG` (pending to pending, new tag): a dispatch renames a register that is already pending.
- `T_CAPTURE` (pending to ready): a writeback broadcast carries the tag the entry is waiting on. The entry takes the broadcast value.

The two source ports are combinational. Each returns a ready flag with either a value or a pending tag. A broadcast arriving in the same cycle is forwarded through to the source ports.

Top module: `tag_rename_table`

## Requirements
- R1: After reset every register reads as ready with value 0.
- R2: A source lookup of a ready register returns ready=1 and its value. A lookup of a pending register that is not being broadcast returns ready=0 and its tag.
- R3: A dispatch with `disp_valid`=1 makes the destination register pending on `disp_tag`, from the next cycle on. Tag codes 0 to 5 stand for stations A to F.
- R4: Source lookups in a dispatch cycle see the table as it was before that cycle's rename. An instruction that reads its own destination therefore gets the older mapping.
- R5: A broadcast whose tag equals a pending register's tag makes that register ready with the broadcast value. Every register waiting on that tag captures it in the same cycle.
- R6: A broadcast whose tag matches no waiting register changes nothing. This includes a broadcast that matches the stale tag of a register that is already ready.
- R7: After a register is renamed twice, a broadcast of the older tag leaves it pending on the newer tag.
- R8: When a rename and a matching broadcast hit the same register in one cycle, the rename wins. The register ends pending on the new tag.
- R9: A lookup of a pending register during a broadcast of its tag returns ready=1 with the broadcast value in that same cycle.
- R10: With `disp_valid`=0, no register is renamed, whatever the other dispatch inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A dispatch happens this cycle |
| disp_dst | input | 3 | Destination register index |
| disp_tag | input | 3 | Allocated station tag (0..5 = A..F) |
| src_a_sel | input | 3 | First source register index |
| src_b_sel | input | 3 | Second source register index |
| wb_valid | input | 1 | Writeback broadcast this cycle |
| wb_tag | input | 3 | Tag of the producing station |
| wb_value | input | 16 | Result being broadcast |
| src_a_ready | output | 1 | First source has a value |
| src_a_tag | output | 3 | First source producer tag when not ready |
| src_a_value | output | 16 | First source value when ready |
| src_b_ready | output | 1 | Second source has a value |
| src_b_tag | output | 3 | Second source producer tag when not ready |
| src_b_value | output | 16 | Second source value when ready |

## Verification
Dispatch renaming and writeback broadcast can land in the same cycle, and they can hit the same register. The bench renames a register and, on the next cycle, renames it again while broadcasting its current tag. It then judges through a plain lookup that the register is pending on the new tag. The same overlap also appears through the source ports: a lookup taken during a matching broadcast must already return the broadcast value. A sweep over every register and every tag compares each cycle's lookups against a cycle model built from the requirements.

// File: rtl/rat_pkg.sv
package rat_pkg;
    typedef enum logic {
        ENT_READY   = 1'b0,
        ENT_PENDING = 1'b1
    } ent_state_e;
endpackage

// File: rtl/rat_entry.sv
module rat_entry
    import rat_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rename_en,
    input  logic [TAG_W-1:0]  rename_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    output logic              ent_valid,
    output logic [TAG_W-1:0]  ent_tag,
    output logic [DATA_W-1:0] ent_value
);
    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] value_q, value_d;
    logic              wb_hit;

    assign wb_hit = wb_valid && (wb_tag == tag_q);

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        value_d = value_q;
        unique case (state_q)
            ENT_READY: begin
                if (rename_en) begin          // T_RENAME
                    state_d = ENT_PENDING;
                    tag_d   = rename_tag;
                end
            end
            ENT_PENDING: begin
                if (rename_en) begin          // T_RETAG, rename has precedence
                    tag_d = rename_tag;
                end else if (wb_hit) begin    // T_CAPTURE
                    state_d = ENT_READY;
                    value_d = wb_value;
                end
            end
            default: state_d = ENT_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_READY;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            value_q <= value_d;
        end
    end

    always_comb begin
        ent_valid = (state_q == ENT_READY);
        ent_tag   = tag_q;
        ent_value = value_q;
    end

    // R3: a rename leaves the entry pending on the new tag
    a_r3_rename_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rename_en |=> (state_q == ENT_PENDING) && (tag_q == $past(rename_tag)));

    // R5: a matching broadcast on a waiting entry is captured
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_en && state_q == ENT_PENDING && wb_valid && wb_tag == tag_q)
        |=> (state_q == ENT_READY) && (value_q == $past(wb_value)));

    // R6: a non-matching broadcast leaves a waiting entry alone
    a_r6_mismatch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_en && state_q == ENT_PENDING && !(wb_valid && wb_tag == tag_q))
        |=> (state_q == ENT_PENDING) && $stable(tag_q));

    // R6: a ready entry keeps its value unless renamed
    a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rename_en && state_q == ENT_READY) |=> (state_q == ENT_READY) && $stable(value_q));
endmodule

// File: rtl/rat_src_port.sv
module rat_src_port #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 3,
    parameter int TAG_W    = 3,
    parameter int DATA_W   = 16
) (
    input  logic [REG_W-1:0]                 sel,
    input  logic [NUM_REGS-1:0]              valid_vec,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_vec,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  value_vec,
    input  logic                             wb_valid,
    input  logic [TAG_W-1:0]                 wb_tag,
    input  logic [DATA_W-1:0]                wb_value,
    output logic                             ready,
    output logic [TAG_W-1:0]                 tag,
    output logic [DATA_W-1:0]                value
);
    logic              pick_valid;
    logic [TAG_W-1:0]  pick_tag;
    logic [DATA_W-1:0] pick_value;

    always_comb begin
        pick_valid = 1'b1;
        pick_tag   = '0;
        pick_value = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == REG_W'(i)) begin
                pick_valid = valid_vec[i];
                pick_tag   = tag_vec[i];
                pick_value = value_vec[i];
            end
        end
    end

    always_comb begin
        ready = pick_valid;
        tag   = pick_tag;
        value = pick_value;
        if (!pick_valid && wb_valid && (wb_tag == pick_tag)) begin
            ready = 1'b1;          // same-cycle forward
            value = wb_value;
        end
    end
endmodule

// File: rtl/tag_rename_table.sv
module tag_rename_table #(
    parameter int NUM_REGS = 6,
    parameter int NUM_TAGS = 6,
    parameter int DATA_W   = 16,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [REG_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic [REG_W-1:0]  src_a_sel,
    input  logic [REG_W-1:0]  src_b_sel,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    output logic              src_a_ready,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_a_value,
    output logic              src_b_ready,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic [DATA_W-1:0] src_b_value
);
    logic [NUM_REGS-1:0]             valid_vec;
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0] value_vec;
    logic [NUM_REGS-1:0]             rename_en;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        assign rename_en[g] = disp_valid && (disp_dst == REG_W'(g));

        rat_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .rename_en  (rename_en[g]),
            .rename_tag (disp_tag),
            .wb_valid   (wb_valid),
            .wb_tag     (wb_tag),
            .wb_value   (wb_value),
            .ent_valid  (valid_vec[g]),
            .ent_tag    (tag_vec[g]),
            .ent_value  (value_vec[g])
        );
    end

    rat_src_port #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_port_a (
        .sel(src_a_sel), .valid_vec(valid_vec), .tag_vec(tag_vec), .value_vec(value_vec),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .ready(src_a_ready), .tag(src_a_tag), .value(src_a_value)
    );

    rat_src_port #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_port_b (
        .sel(src_b_sel), .valid_vec(valid_vec), .tag_vec(tag_vec), .value_vec(value_vec),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .ready(src_b_ready), .tag(src_b_tag), .value(src_b_value)
    );

    // R10: without a dispatch no register goes from ready to pending
    a_r10_no_dispatch_no_rename: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_valid |=> (($past(valid_vec) & ~valid_vec) == '0));

    // R8: a renamed register is never ready in the following cycle
    a_r8_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_dst < REG_W'(NUM_REGS)) |=> !valid_vec[$past(disp_dst)]);
endmodule

// File: tb/test_tag_rename_table.sv
module test_tag_rename_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [2:0]  disp_dst = '0, disp_tag = '0, src_a_sel = '0, src_b_sel = '0;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [15:0] wb_value = '0;
    logic        src_a_ready, src_b_ready;
    logic [2:0]  src_a_tag, src_b_tag;
    logic [15:0] src_a_value, src_b_value;

    int checks = 0;
    int errors = 0;

    bit          m_valid [6];
    int          m_tag   [6];
    logic [15:0] m_value [6];

    always #10 clk = ~clk;   // 50 MHz

    tag_rename_table i_tag_rename_table (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_tag(disp_tag), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .src_a_ready(src_a_ready), .src_a_tag(src_a_tag), .src_a_value(src_a_value),
        .src_b_ready(src_b_ready), .src_b_tag(src_b_tag), .src_b_value(src_b_value)
    );

    task automatic check_port(input string req, input string port, input int sel,
                              input logic rdy, input logic [2:0] tg, input logic [15:0] val);
        bit          e_rdy;
        int          e_tag;
        logic [15:0] e_val;
        e_rdy = m_valid[sel];
        e_tag = m_tag[sel];
        e_val = m_value[sel];
        if (!e_rdy && wb_valid && int'(wb_tag) == e_tag) begin
            e_rdy = 1'b1;
            e_val = wb_value;
        end
        checks++;
        if (rdy !== e_rdy || (e_rdy && val !== e_val) || (!e_rdy && int'(tg) != e_tag)) begin
            errors++;
            $display("FAIL %s port %s reg %0d: got ready=%0b tag=%0d value=%h, expected ready=%0b tag=%0d value=%h",
                     req, port, sel, rdy, tg, val, e_rdy, e_tag, e_val);
        end
    endtask

    task automatic step(input bit dv, input int dst, input int dtag, input int sa, input int sb,
                        input bit wv, input int wtg, input logic [15:0] wval, input string req);
        @(negedge clk);
        disp_valid = dv;  disp_dst = 3'(dst);  disp_tag = 3'(dtag);
        src_a_sel = 3'(sa); src_b_sel = 3'(sb);
        wb_valid = wv;    wb_tag = 3'(wtg);    wb_value = wval;
        #5;
        check_port(req, "a", sa, src_a_ready, src_a_tag, src_a_value);
        check_port(req, "b", sb, src_b_ready, src_b_tag, src_b_value);
        @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            if (dv && dst == i) begin
                m_valid[i] = 1'b0;
                m_tag[i]   = dtag;
            end else if (!m_valid[i] && wv && wtg == m_tag[i]) begin
                m_valid[i] = 1'b1;
                m_value[i] = wval;
            end
        end
    endtask

    task automatic idle_read(input int sa, input int sb, input string req);
        step(1'b0, 0, 0, sa, sb, 1'b0, 0, 16'h0, req);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_valid[i] = 1'b1; m_tag[i] = 0; m_value[i] = 16'h0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state of every register
        for (int r = 0; r < 6; r++) idle_read(r, 5 - r, "R1");

        // Sweep: every register with every tag
        for (int r = 0; r < 6; r++) begin
            for (int t = 0; t < 6; t++) begin
                logic [16:0] v;
                v = 17'(16'h1000 + r * 256 + t * 7);
                step(1'b1, r, t, r, (r + 1) % 6, 1'b0, 0, 16'h0, "R4");
                idle_read(r, r, "R3");
                step(1'b0, 0, 0, r, r, 1'b1, (t + 1) % 6, 16'hDEAD, "R6");
                idle_read(r, (r + 2) % 6, "R2");
                step(1'b0, 0, 0, r, (r + 3) % 6, 1'b1, t, v[15:0], "R9");
                idle_read(r, r, "R5");
            end
        end

        // R7: older tag broadcast after a second rename
        step(1'b1, 2, 0, 2, 2, 1'b0, 0, 16'h0, "R7");
        step(1'b1, 2, 1, 2, 2, 1'b0, 0, 16'h0, "R7");
        step(1'b0, 0, 0, 2, 2, 1'b1, 0, 16'hAAAA, "R7");
        idle_read(2, 2, "R7");
        step(1'b0, 0, 0, 2, 2, 1'b1, 1, 16'hBBBB, "R7");
        idle_read(2, 2, "R7");

        // R8: rename and matching broadcast in one cycle
        step(1'b1, 3, 3, 3, 3, 1'b0, 0, 16'h0, "R8");
        step(1'b1, 3, 4, 0, 1, 1'b1, 3, 16'h3333, "R8");
        idle_read(3, 3, "R8");
        step(1'b0, 0, 0, 3, 0, 1'b1, 4, 16'h4444, "R8");
        idle_read(3, 3, "R8");

        // R5: three registers waiting on one tag
        step(1'b1, 0, 5, 0, 1, 1'b0, 0, 16'h0, "R5");
        step(1'b1, 1, 5, 0, 1, 1'b0, 0, 16'h0, "R5");
        step(1'b1, 4, 5, 1, 4, 1'b0, 0, 16'h0, "R5");
        step(1'b0, 0, 0, 0, 4, 1'b1, 5, 16'h5A5A, "R5");
        idle_read(0, 1, "R5");
        idle_read(4, 2, "R5");

        // R6: broadcast of a stale tag to a ready register
        step(1'b0, 0, 0, 5, 5, 1'b1, 5, 16'hFFFF, "R6");
        idle_read(5, 0, "R6");

        // R10: dispatch inputs without disp_valid
        for (int r = 0; r < 6; r++) begin
            step(1'b0, r, 2, r, r, 1'b0, 0, 16'h0, "R10");
            idle_read(r, r, "R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got no finish, expected finish before 20000 cycles");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule